// File: doc/BRIEF.md
# SDRAM Open-Row Tracker

This block sits in front of an SDRAM command sequencer. It remembers which row is open in each bank. Here a bank is the pair of a chip select and an internal bank address. Each incoming request carries a byte address, a flag that selects the reduced-column addressing mode, and a flag that selects a 64-bit memory width. The block splits the address into column, internal bank, chip select and row. It compares that target against what is open and classifies the access as a page hit, a page miss or a bank miss.

The controller is told what to do next. A hit needs no row command. Any miss needs an activate of the new row on the target bank, and a precharge of the bank that was accessed last. The precharge is raised only when that last bank is still open. The column field depends only on the addressing mode and the width, never on the device's column geometry. The standard modes keep 9 column bits (512 columns per page). The reduced mode keeps 8 (256 columns). With a 32-bit width that gives pages of 2 KB and 1 KB, and with a 64-bit width pages of 4 KB and 2 KB. A precharge-all input closes every bank.

Each request produces a registered response on the following clock edge.

Top module: `spt_page_tracker`

## Requirements
- R1: A request sampled with `reqValid` high produces exactly one response with `respValid` high on the next clock edge. `respValid` is low after any cycle without a request, and all response outputs are low after reset.
- R2: With `reqWide`=0 and `reqMode4`=0, the outputs take these address bits: column = addr[10:2] (9 bits), internal bank = addr[12:11], chip select = addr[14:13], row = addr[27:15].
- R3: With `reqWide`=0 and `reqMode4`=1, the column is {0, addr[9:2]}, so the column MSB is always 0. The internal bank is addr[11:10], the chip select addr[13:12] and the row addr[26:14].
- R4: With `reqWide`=1 the byte offset is 3 bits. In the standard modes: column = addr[11:3], bank = addr[13:12], chip select = addr[15:14], row = addr[28:16]. In the reduced mode: column = {0, addr[10:3]}, bank = addr[12:11], chip select = addr[14:13], row = addr[27:15].
- R5: `respClass` encodes 2'b01 = page hit, 2'b10 = page miss, 2'b11 = bank miss. A page hit occurs only when the target bank is open with the same row, and it raises neither `respActivate` nor `respPrecharge`.
- R6: A page miss occurs on an access to the same chip select and internal bank as the previous access but to a different row. It raises `respActivate`, plus `respPrecharge` with `respPreCs`/`respPreBank` equal to that same bank.
- R7: A bank miss occurs on an access whose chip select or internal bank differs from the previous access. It raises `respActivate`. If the previous bank is open, it also raises `respPrecharge` with `respPreCs`/`respPreBank` naming the previous bank.
- R8: The first access after reset is a bank miss with `respPrecharge` low.
- R9: `prechargeAll` closes every bank. An access in the same cycle as `prechargeAll` sees all banks closed, so it is a bank miss with `respPrecharge` low.
- R10: After a miss the new row is open in the target bank, and a repeat access there is a hit. The previously accessed bank is closed by the miss, so a later return to it is a bank miss even with the old row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe |
| reqAddr | input | 32 | Byte address of the request |
| reqMode4 | input | 1 | 1 selects reduced-column (8-bit) addressing |
| reqWide | input | 1 | 1 selects 64-bit memory width |
| prechargeAll | input | 1 | Closes every bank |
| respValid | output | 1 | Response strobe |
| respClass | output | 2 | 01 hit, 10 page miss, 11 bank miss |
| respRow | output | 13 | Row field of the request |
| respCol | output | 9 | Column field of the request |
| respCs | output | 2 | Chip select of the request |
| respBank | output | 2 | Internal bank of the request |
| respActivate | output | 1 | Activate the row on the target bank |
| respPrecharge | output | 1 | Precharge the bank named below |
| respPreCs | output | 2 | Chip select of the bank to precharge |
| respPreBank | output | 2 | Internal bank of the bank to precharge |

## Verification
The hardest situation to reach is a request that arrives in the same cycle as `prechargeAll` and targets the very row that was just opened. Only the same-cycle ordering turns what would be a hit into a bank miss without a precharge. The stimulus opens a row, confirms a hit on it, and then drives the flush together with a repeat of that address. A second path returns to a bank that was closed by a switch away and reuses its old row. This shows that a stored row cannot produce a hit once its bank has been precharged.

// File: rtl/spt_pkg.sv
package spt_pkg;

  typedef enum logic [1:0] {
    CLS_IDLE      = 2'b00,
    CLS_HIT       = 2'b01,
    CLS_PAGE_MISS = 2'b10,
    CLS_BANK_MISS = 2'b11
  } accessClass_e;

  // Strobes from the control decision to the datapath registers.
  typedef struct packed {
    logic         capture;
    logic         flushAll;
    logic         openTarget;
    logic         precharge;
    accessClass_e cls;
  } trackStrobes_t;

endpackage

// File: rtl/spt_addr_split.sv
module spt_addr_split #(
  parameter int ADDR_W = 32,
  parameter int ROW_W  = 13,
  parameter int CS_W   = 2,
  parameter int BANK_W = 2,
  parameter int COL_W  = 9
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              isMode4,
  input  logic              isWide,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col,
  output logic [CS_W-1:0]   cs,
  output logic [BANK_W-1:0] bank
);
  localparam int UPPER_W = BANK_W + CS_W + ROW_W;
  localparam int WORD_W  = COL_W + UPPER_W;

  logic [WORD_W-1:0]  wordAddr;
  logic [UPPER_W-1:0] upperAddr;
  logic               unusedAddrBits;

  assign unusedAddrBits = ^{addr[1:0], addr[ADDR_W-1:WORD_W+3]};

  always_comb begin
    // Drop the byte offset: 4-byte or 8-byte words.
    wordAddr  = isWide ? addr[3 +: WORD_W] : addr[2 +: WORD_W];
    // Reduced mode takes one column bit fewer.
    upperAddr = isMode4 ? wordAddr[COL_W-1 +: UPPER_W] : wordAddr[COL_W +: UPPER_W];
    col       = isMode4 ? {1'b0, wordAddr[COL_W-2:0]} : wordAddr[COL_W-1:0];
    bank      = upperAddr[BANK_W-1:0];
    cs        = upperAddr[BANK_W +: CS_W];
    row       = upperAddr[BANK_W+CS_W +: ROW_W];
  end
endmodule

// File: rtl/spt_control.sv
module spt_control import spt_pkg::*; (
  input  logic          reqValid,
  input  logic          prechargeAll,
  input  logic          rowMatch,
  input  logic          targetActive,
  input  logic          sameBank,
  input  logic          lastValid,
  input  logic          lastActive,
  output trackStrobes_t strobes
);
  logic liveLast;
  logic isHit;
  logic isPageMiss;

  always_comb begin
    // A flush in the same cycle wins over the stored state.
    liveLast   = lastValid && !prechargeAll;
    isHit      = !prechargeAll && targetActive && rowMatch;
    isPageMiss = liveLast && sameBank && !isHit;

    strobes          = '0;
    strobes.flushAll = prechargeAll;
    strobes.capture  = reqValid;
    if (reqValid) begin
      strobes.openTarget = !isHit;
      strobes.precharge  = !isHit && liveLast && lastActive;
      if (isHit)           strobes.cls = CLS_HIT;
      else if (isPageMiss) strobes.cls = CLS_PAGE_MISS;
      else                 strobes.cls = CLS_BANK_MISS;
    end
  end
endmodule

// File: rtl/spt_datapath.sv
module spt_datapath import spt_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int ROW_W  = 13,
  parameter int CS_W   = 2,
  parameter int BANK_W = 2,
  parameter int COL_W  = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqMode4,
  input  logic              reqWide,
  input  trackStrobes_t     strobes,
  output logic              rowMatch,
  output logic              targetActive,
  output logic              sameBank,
  output logic              lastValid,
  output logic              lastActive,
  output logic              respValid,
  output logic [1:0]        respClass,
  output logic [ROW_W-1:0]  respRow,
  output logic [COL_W-1:0]  respCol,
  output logic [CS_W-1:0]   respCs,
  output logic [BANK_W-1:0] respBank,
  output logic              respActivate,
  output logic              respPrecharge,
  output logic [CS_W-1:0]   respPreCs,
  output logic [BANK_W-1:0] respPreBank
);
  localparam int IDX_W     = CS_W + BANK_W;
  localparam int NUM_BANKS = 1 << IDX_W;

  logic [ROW_W-1:0]  reqRow;
  logic [COL_W-1:0]  reqCol;
  logic [CS_W-1:0]   reqCs;
  logic [BANK_W-1:0] reqBank;
  logic [IDX_W-1:0]  targetIdx;
  logic [IDX_W-1:0]  lastIdx;

  logic [NUM_BANKS-1:0] activeFlags;
  logic [ROW_W-1:0]     openRow [NUM_BANKS];

  spt_addr_split #(
    .ADDR_W(ADDR_W), .ROW_W(ROW_W), .CS_W(CS_W), .BANK_W(BANK_W), .COL_W(COL_W)
  ) u_split (
    .addr   (reqAddr),
    .isMode4(reqMode4),
    .isWide (reqWide),
    .row    (reqRow),
    .col    (reqCol),
    .cs     (reqCs),
    .bank   (reqBank)
  );

  assign targetIdx    = {reqCs, reqBank};
  assign rowMatch     = (openRow[targetIdx] == reqRow);
  assign targetActive = activeFlags[targetIdx];
  assign sameBank     = (lastIdx == targetIdx);
  assign lastActive   = activeFlags[lastIdx];

  // Row storage per bank, written on each activate.
  genvar gi;
  generate
    for (gi = 0; gi < NUM_BANKS; gi++) begin : g_row
      always_ff @(posedge clk) begin
        if (strobes.openTarget && (targetIdx == IDX_W'(gi)))
          openRow[gi] <= reqRow;
      end
    end
  endgenerate

  // Open flags and last-accessed bank. Later statements take priority.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeFlags <= '0;
      lastIdx     <= '0;
      lastValid   <= 1'b0;
    end else begin
      if (strobes.flushAll) begin
        activeFlags <= '0;
        lastValid   <= 1'b0;
      end
      if (strobes.precharge)  activeFlags[lastIdx]   <= 1'b0;
      if (strobes.openTarget) activeFlags[targetIdx] <= 1'b1;
      if (strobes.capture) begin
        lastIdx   <= targetIdx;
        lastValid <= 1'b1;
      end
    end
  end

  // Registered response.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid     <= 1'b0;
      respClass     <= 2'b00;
      respRow       <= '0;
      respCol       <= '0;
      respCs        <= '0;
      respBank      <= '0;
      respActivate  <= 1'b0;
      respPrecharge <= 1'b0;
      respPreCs     <= '0;
      respPreBank   <= '0;
    end else begin
      respValid <= strobes.capture;
      if (strobes.capture) begin
        respClass     <= strobes.cls;
        respRow       <= reqRow;
        respCol       <= reqCol;
        respCs        <= reqCs;
        respBank      <= reqBank;
        respActivate  <= strobes.openTarget;
        respPrecharge <= strobes.precharge;
        respPreCs     <= lastIdx[BANK_W +: CS_W];
        respPreBank   <= lastIdx[BANK_W-1:0];
      end
    end
  end
endmodule

// File: rtl/spt_page_tracker.sv
module spt_page_tracker import spt_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int ROW_W  = 13,
  parameter int CS_W   = 2,
  parameter int BANK_W = 2,
  parameter int COL_W  = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqMode4,
  input  logic              reqWide,
  input  logic              prechargeAll,
  output logic              respValid,
  output logic [1:0]        respClass,
  output logic [ROW_W-1:0]  respRow,
  output logic [COL_W-1:0]  respCol,
  output logic [CS_W-1:0]   respCs,
  output logic [BANK_W-1:0] respBank,
  output logic              respActivate,
  output logic              respPrecharge,
  output logic [CS_W-1:0]   respPreCs,
  output logic [BANK_W-1:0] respPreBank
);
  trackStrobes_t strobes;
  logic rowMatch, targetActive, sameBank, lastValid, lastActive;

  spt_control u_ctrl (
    .reqValid    (reqValid),
    .prechargeAll(prechargeAll),
    .rowMatch    (rowMatch),
    .targetActive(targetActive),
    .sameBank    (sameBank),
    .lastValid   (lastValid),
    .lastActive  (lastActive),
    .strobes     (strobes)
  );

  spt_datapath #(
    .ADDR_W(ADDR_W), .ROW_W(ROW_W), .CS_W(CS_W), .BANK_W(BANK_W), .COL_W(COL_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .reqAddr      (reqAddr),
    .reqMode4     (reqMode4),
    .reqWide      (reqWide),
    .strobes      (strobes),
    .rowMatch     (rowMatch),
    .targetActive (targetActive),
    .sameBank     (sameBank),
    .lastValid    (lastValid),
    .lastActive   (lastActive),
    .respValid    (respValid),
    .respClass    (respClass),
    .respRow      (respRow),
    .respCol      (respCol),
    .respCs       (respCs),
    .respBank     (respBank),
    .respActivate (respActivate),
    .respPrecharge(respPrecharge),
    .respPreCs    (respPreCs),
    .respPreBank  (respPreBank)
  );
endmodule

// File: rtl/spt_page_tracker_chk.sv
module spt_page_tracker_chk #(
  parameter int CS_W   = 2,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqMode4,
  input logic              prechargeAll,
  input logic              respValid,
  input logic [1:0]        respClass,
  input logic              respColTop,
  input logic [CS_W-1:0]   respCs,
  input logic [BANK_W-1:0] respBank,
  input logic              respActivate,
  input logic              respPrecharge,
  input logic [CS_W-1:0]   respPreCs,
  input logic [BANK_W-1:0] respPreBank
);
  assert_resp_follows_req_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid);

  assert_no_spurious_resp_R1: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid);

  assert_mode4_col_msb_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqMode4) |=> !respColTop);

  assert_hit_no_command_R5: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respClass == 2'b01) |-> (!respActivate && !respPrecharge));

  assert_page_miss_same_bank_R6: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respClass == 2'b10) |->
      (respActivate && respPrecharge && respPreCs == respCs && respPreBank == respBank));

  assert_bank_miss_other_bank_R7: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respClass == 2'b11) |->
      (respActivate && (!respPrecharge || {respPreCs, respPreBank} != {respCs, respBank})));

  assert_flush_first_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && prechargeAll) |=> (respClass == 2'b11 && !respPrecharge));
endmodule

bind spt_page_tracker spt_page_tracker_chk #(.CS_W(CS_W), .BANK_W(BANK_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .reqMode4     (reqMode4),
  .prechargeAll (prechargeAll),
  .respValid    (respValid),
  .respClass    (respClass),
  .respColTop   (respCol[COL_W-1]),
  .respCs       (respCs),
  .respBank     (respBank),
  .respActivate (respActivate),
  .respPrecharge(respPrecharge),
  .respPreCs    (respPreCs),
  .respPreBank  (respPreBank)
);

// File: tb/spt_page_tracker_test.sv
`timescale 1ns/1ps
module spt_page_tracker_test;
  localparam int ADDR_W = 32;
  localparam int ROW_W  = 13;
  localparam int CS_W   = 2;
  localparam int BANK_W = 2;
  localparam int COL_W  = 9;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              reqMode4 = 1'b0;
  logic              reqWide = 1'b0;
  logic              prechargeAll = 1'b0;
  logic              respValid;
  logic [1:0]        respClass;
  logic [ROW_W-1:0]  respRow;
  logic [COL_W-1:0]  respCol;
  logic [CS_W-1:0]   respCs;
  logic [BANK_W-1:0] respBank;
  logic              respActivate;
  logic              respPrecharge;
  logic [CS_W-1:0]   respPreCs;
  logic [BANK_W-1:0] respPreBank;

  always #2 clk = ~clk;

  spt_page_tracker uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqMode4(reqMode4), .reqWide(reqWide), .prechargeAll(prechargeAll),
    .respValid(respValid), .respClass(respClass), .respRow(respRow),
    .respCol(respCol), .respCs(respCs), .respBank(respBank),
    .respActivate(respActivate), .respPrecharge(respPrecharge),
    .respPreCs(respPreCs), .respPreBank(respPreBank)
  );

  typedef struct packed {
    logic [1:0]        cls;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
    logic [CS_W-1:0]   cs;
    logic [BANK_W-1:0] bank;
    logic              act;
    logic              pre;
    logic [CS_W-1:0]   pcs;
    logic [BANK_W-1:0] pbank;
  } item_t;

  item_t expQ[$];
  string tagQ[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference: only the most recently accessed bank can be open.
  bit                mOpen = 1'b0;
  logic [CS_W-1:0]   mCs   = '0;
  logic [BANK_W-1:0] mBank = '0;
  logic [ROW_W-1:0]  mRow  = '0;

  task automatic send(input bit wide, input bit m4, input int row, input int cs,
                      input int bank, input int col, input bit flush, input string tag);
    item_t e;
    logic [ADDR_W-1:0] a;
    int sh, cw;
    sh = wide ? 3 : 2;
    cw = m4 ? 8 : 9;
    a = (ADDR_W'(row) << (sh + cw + 4)) | (ADDR_W'(cs) << (sh + cw + 2)) |
        (ADDR_W'(bank) << (sh + cw)) | (ADDR_W'(col) << sh) |
        ADDR_W'((row + col) & ((1 << sh) - 1));
    if (flush) mOpen = 1'b0;
    if (mOpen && mCs == CS_W'(cs) && mBank == BANK_W'(bank))
      e.cls = (mRow == ROW_W'(row)) ? 2'b01 : 2'b10;
    else
      e.cls = 2'b11;
    e.row   = ROW_W'(row);
    e.col   = COL_W'(m4 ? (col & 255) : (col & 511));
    e.cs    = CS_W'(cs);
    e.bank  = BANK_W'(bank);
    e.act   = (e.cls != 2'b01);
    e.pre   = mOpen && (e.cls != 2'b01);
    e.pcs   = mCs;
    e.pbank = mBank;
    mOpen = 1'b1; mCs = CS_W'(cs); mBank = BANK_W'(bank); mRow = ROW_W'(row);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqMode4 = m4; reqWide = wide; prechargeAll = flush;
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic flushOnly();
    @(negedge clk);
    reqValid = 1'b0; prechargeAll = 1'b1;
    mOpen = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reqValid = 1'b0; prechargeAll = 1'b0;
    end
  endtask

  // Monitor: pops expected items as responses appear.
  initial begin
    item_t e, got;
    string t;
    forever begin
      @(negedge clk);
      if (rstN && respValid) begin
        checks++;
        if (expQ.size() == 0) begin
          fails++;
          $display("FAIL R1: response with none expected, actual respValid=1 expected 0");
        end else begin
          e = expQ.pop_front();
          t = tagQ.pop_front();
          got = '{respClass, respRow, respCol, respCs, respBank, respActivate,
                  respPrecharge, respPreCs, respPreBank};
          if (!e.pre) begin
            got.pcs   = e.pcs;
            got.pbank = e.pbank;
          end
          if (got !== e) begin
            fails++;
            $display("FAIL %s: actual cls=%b row=%0d col=%0d cs=%0d bank=%0d act=%b pre=%b pcs=%0d pbank=%0d expected cls=%b row=%0d col=%0d cs=%0d bank=%0d act=%b pre=%b pcs=%0d pbank=%0d",
                     t, got.cls, got.row, got.col, got.cs, got.bank, got.act, got.pre, got.pcs, got.pbank,
                     e.cls, e.row, e.col, e.cs, e.bank, e.act, e.pre, e.pcs, e.pbank);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual run still busy, expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (respValid !== 1'b0 || respActivate !== 1'b0 || respPrecharge !== 1'b0 || respClass !== 2'b00) begin
      fails++;
      $display("FAIL R1: reset state actual valid=%b act=%b pre=%b cls=%b expected all 0",
               respValid, respActivate, respPrecharge, respClass);
    end

    // 32-bit, standard modes
    send(0, 0, 5, 1, 2, 7, 0, "R8 first access bank miss");
    send(0, 0, 5, 1, 2, 100, 0, "R5 hit same row");
    send(0, 0, 9, 1, 2, 3, 0, "R6 page miss");
    send(0, 0, 9, 2, 2, 3, 0, "R7 bank miss by chip select");
    send(0, 0, 9, 2, 3, 4, 0, "R7 bank miss by internal bank");
    send(0, 0, 9, 2, 2, 5, 0, "R10 return to closed bank");
    send(0, 0, 9, 2, 2, 6, 0, "R10 reopened row hits");
    idle(2);
    flushOnly();
    send(0, 0, 9, 2, 2, 6, 0, "R9 access after flush");
    send(0, 0, 9, 2, 2, 8, 0, "R5 hit after reopen");
    send(0, 0, 9, 2, 2, 8, 1, "R9 flush same cycle");
    send(0, 0, 8191, 3, 3, 511, 0, "R2 field limits");
    // 32-bit, reduced mode
    send(0, 1, 4095, 0, 1, 255, 0, "R3 reduced column");
    send(0, 1, 4095, 0, 1, 17, 0, "R3 reduced hit");
    // 64-bit width
    send(1, 0, 6000, 1, 0, 511, 0, "R4 wide standard");
    send(1, 0, 6000, 1, 0, 256, 0, "R4 wide standard hit");
    send(1, 1, 77, 3, 1, 200, 0, "R4 wide reduced");
    send(1, 1, 78, 3, 1, 201, 0, "R6 page miss wide reduced");
    idle(4);

    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R1: responses missing, actual pending=%0d expected 0", expQ.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule